// File: doc/BRIEF.md
# Bus Read Retry and Abandon Controller

This controller takes read requests from an internal queue and drives them onto a target bus whose target may answer any read with a retry instead of data. It keeps at most one read waiting in a single holding slot and at most one read on the bus. Each retry of the read on the bus is counted against a limit supplied on a programmable input.

When a read runs past that limit for the first time, the controller gives up the bus. Other waiting traffic, meaning posted writes and returning read data, is granted until none of it remains. The read is then sent again with a fresh count. If the second attempt also runs past the limit, the read is dropped and reported with an error completion. A normal answer from the target ends the read with an OK completion that carries the returned data and the read's address.

Top module: `bus_read_retry_ctrl`

## Requirements
- R1: A single holding slot accepts a read when `req_valid` is high while `req_ready` is high. `req_ready` is low exactly while the slot is occupied. A request offered while the slot is occupied is not taken and is never issued.
- R2: The controller can start a held read only when no read is on the bus. In that case the read appears as a one-cycle `bus_issue` pulse, with `bus_addr` equal to its address, in the cycle after the controller is idle with the slot full. `bus_issue` is never high in two consecutive cycles.
- R3: A retry (`rsp_retry`) whose running count, including that retry, is not above `retry_limit` causes a new `bus_issue` pulse in the next cycle. The count starts at zero each time a read is first issued and again when a yielded read is reissued.
- R4: The first retry that takes the count above the limit puts the controller into a yield phase with no `bus_issue`. In that phase `byp_grant` follows `byp_pending`. In the cycle after a clock edge that sees `byp_pending` low, the read is issued again to the same address.
- R5: A retry that takes the count above the limit during the reissued attempt abandons the read. `cpl_valid` and `cpl_err` then pulse high together two cycles after that retry, with `cpl_addr` equal to the read's address.
- R6: `rsp_done` on a read on the bus gives, in the next cycle, a one-cycle `cpl_valid` with `cpl_err` low, `cpl_data` equal to `rsp_data`, and `cpl_addr` equal to the read's address. A read that finished this way leaves no trace on the next read: that read's first limit overrun yields and does not abandon.
- R7: A `retry_limit` of zero makes every retry an overrun. The first retry yields and the retry on the reissued attempt abandons.
- R8: `byp_grant` is high only when `byp_pending` is high and the controller is either idle or yielding. It is never high while a read is being issued or is awaiting its answer.
- R9: After a completion of either kind, the controller is idle again and takes the next held read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request offered |
| req_addr | input | AW | Address of the offered read |
| req_ready | output | 1 | Holding slot empty, request can be taken |
| bus_issue | output | 1 | One-cycle pulse: place the read on the bus |
| bus_addr | output | AW | Address of the read on the bus |
| rsp_retry | input | 1 | Target asked for the read to be retried |
| rsp_done | input | 1 | Target answered the read with data |
| rsp_data | input | DW | Data returned with `rsp_done` |
| retry_limit | input | LW | Number of retries tolerated per attempt |
| byp_pending | input | 1 | Writes or read-data returns are waiting for the bus |
| byp_grant | output | 1 | Waiting writes or read-data returns may use the bus |
| cpl_valid | output | 1 | One-cycle completion pulse |
| cpl_err | output | 1 | Completion is an abandoned read (bus error) |
| cpl_addr | output | AW | Address of the completed read |
| cpl_data | output | DW | Returned data (zero on error) |

## Verification
Each result has a fixed due cycle. A held read shows `bus_issue` one cycle after the cycle in which it is accepted. A retry within the limit re-raises `bus_issue` in the next cycle. `rsp_done` produces `cpl_valid` one cycle later, while an abandoning retry produces it two cycles later, because the error state sits in between. After `byp_pending` falls, the read is reissued one cycle later. The bench drives every input on the falling clock edge and samples at the following falling edge, or at as many falling edges as the count above demands. It also checks in the cycles just before each result is due that the result is not there early.

// File: rtl/rrc_pkg.sv
package rrc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_ISSUE   = 3'd1,
    ST_WAIT    = 3'd2,
    ST_YIELD   = 3'd3,
    ST_REISSUE = 3'd4,
    ST_ERROR   = 3'd5
  } rrc_state_e;

endpackage

// File: rtl/rrc_hold_slot.sv
module rrc_hold_slot #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic          pop,
  output logic          full,
  output logic [AW-1:0] head_addr
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full      <= 1'b0;
      head_addr <= '0;
    end else if (push && !full) begin
      full      <= 1'b1;
      head_addr <= push_addr;
    end else if (pop) begin
      full      <= 1'b0;
    end
  end

endmodule

// File: rtl/rrc_retry_count.sv
module rrc_retry_count #(
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          bump,
  input  logic [LW-1:0] limit,
  output logic [LW:0]   count,
  output logic          over_limit
);

  localparam int CW = LW + 1;

  // True when one more retry would take the count above the limit.
  function automatic logic next_exceeds(input logic [CW-1:0] c,
                                        input logic [LW-1:0] lim);
    logic [CW-1:0] nxt;
    nxt = c + CW'(1);
    return nxt > {1'b0, lim};
  endfunction

  assign over_limit = next_exceeds(count, limit);

  always_ff @(posedge clk) begin
    if (!rst_n)      count <= '0;
    else if (clear)  count <= '0;
    else if (bump)   count <= count + CW'(1);
  end

endmodule

// File: rtl/rrc_ctrl_fsm.sv
module rrc_ctrl_fsm
  import rrc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       slot_full,
  input  logic       rsp_retry,
  input  logic       rsp_done,
  input  logic       over_limit,
  input  logic       byp_pending,
  output rrc_state_e state,
  output logic       second_try,
  output logic       take_slot,
  output logic       cnt_clear,
  output logic       cnt_bump,
  output logic       issue,
  output logic       grant,
  output logic       ok_evt,
  output logic       err_evt
);

  rrc_state_e nxt;
  logic       set_second;

  always_comb begin
    nxt        = state;
    take_slot  = 1'b0;
    cnt_clear  = 1'b0;
    cnt_bump   = 1'b0;
    ok_evt     = 1'b0;
    err_evt    = 1'b0;
    set_second = 1'b0;
    unique case (state)
      ST_IDLE: if (slot_full) begin
        nxt       = ST_ISSUE;
        take_slot = 1'b1;
        cnt_clear = 1'b1;
      end
      ST_ISSUE, ST_REISSUE: nxt = ST_WAIT;
      ST_WAIT: begin
        if (rsp_done) begin
          nxt    = ST_IDLE;
          ok_evt = 1'b1;
        end else if (rsp_retry) begin
          if (!over_limit) begin
            nxt      = ST_ISSUE;
            cnt_bump = 1'b1;
          end else if (second_try) begin
            nxt = ST_ERROR;
          end else begin
            nxt = ST_YIELD;
          end
        end
      end
      ST_YIELD: if (!byp_pending) begin
        nxt        = ST_REISSUE;
        cnt_clear  = 1'b1;
        set_second = 1'b1;
      end
      ST_ERROR: begin
        nxt     = ST_IDLE;
        err_evt = 1'b1;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  assign issue = (state == ST_ISSUE) || (state == ST_REISSUE);
  assign grant = byp_pending && ((state == ST_IDLE) || (state == ST_YIELD));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      second_try <= 1'b0;
    end else begin
      state <= nxt;
      if (set_second)                             second_try <= 1'b1;
      else if (ok_evt || err_evt || take_slot)    second_try <= 1'b0;
    end
  end

endmodule

// File: rtl/bus_read_retry_ctrl.sv
module bus_read_retry_ctrl
  import rrc_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  output logic          req_ready,
  output logic          bus_issue,
  output logic [AW-1:0] bus_addr,
  input  logic          rsp_retry,
  input  logic          rsp_done,
  input  logic [DW-1:0] rsp_data,
  input  logic [LW-1:0] retry_limit,
  input  logic          byp_pending,
  output logic          byp_grant,
  output logic          cpl_valid,
  output logic          cpl_err,
  output logic [AW-1:0] cpl_addr,
  output logic [DW-1:0] cpl_data
);

  // Named internal events, observed by the bound checker.
  logic          slot_full;
  logic [AW-1:0] slot_addr;
  logic          take_slot;
  logic          cnt_clear;
  logic          cnt_bump;
  logic          over_limit;
  logic [LW:0]   retry_cnt;
  logic          second_try;
  logic          ok_evt;
  logic          err_evt;
  rrc_state_e    st;
  logic [AW-1:0] live_addr;

  assign req_ready = !slot_full;

  rrc_hold_slot #(.AW(AW)) u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (req_valid),
    .push_addr (req_addr),
    .pop       (take_slot),
    .full      (slot_full),
    .head_addr (slot_addr)
  );

  rrc_retry_count #(.LW(LW)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (cnt_clear),
    .bump       (cnt_bump),
    .limit      (retry_limit),
    .count      (retry_cnt),
    .over_limit (over_limit)
  );

  rrc_ctrl_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .slot_full   (slot_full),
    .rsp_retry   (rsp_retry),
    .rsp_done    (rsp_done),
    .over_limit  (over_limit),
    .byp_pending (byp_pending),
    .state       (st),
    .second_try  (second_try),
    .take_slot   (take_slot),
    .cnt_clear   (cnt_clear),
    .cnt_bump    (cnt_bump),
    .issue       (bus_issue),
    .grant       (byp_grant),
    .ok_evt      (ok_evt),
    .err_evt     (err_evt)
  );

  assign bus_addr = live_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_addr <= '0;
      cpl_valid <= 1'b0;
      cpl_err   <= 1'b0;
      cpl_addr  <= '0;
      cpl_data  <= '0;
    end else begin
      if (take_slot) live_addr <= slot_addr;
      cpl_valid <= ok_evt || err_evt;
      if (ok_evt) begin
        cpl_err  <= 1'b0;
        cpl_addr <= live_addr;
        cpl_data <= rsp_data;
      end else if (err_evt) begin
        cpl_err  <= 1'b1;
        cpl_addr <= live_addr;
        cpl_data <= '0;
      end
    end
  end

endmodule

// File: rtl/bus_read_retry_ctrl_chk.sv
module bus_read_retry_ctrl_chk
  import rrc_pkg::*;
#(
  parameter int LW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          slot_full,
  input logic          bus_issue,
  input logic          rsp_retry,
  input logic          rsp_done,
  input logic [LW-1:0] retry_limit,
  input logic          byp_grant,
  input logic          cpl_valid,
  input logic          cpl_err,
  input rrc_state_e    st,
  input logic          second_try,
  input logic [LW:0]   retry_cnt
);

  a_r1_fill_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(slot_full) |-> $past(req_valid));

  a_r2_issue_single: assert property (@(posedge clk) disable iff (!rst_n)
    bus_issue |=> !bus_issue);

  a_r3_fresh_count: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ISSUE && $past(st) == ST_IDLE) |-> retry_cnt == '0);

  a_r3_count_in_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT) |-> retry_cnt <= {1'b0, retry_limit});

  a_r4_yield_first_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_YIELD && $past(st) == ST_WAIT) |-> ($past(rsp_retry) && !$past(second_try)));

  a_r5_error_second_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ERROR) |-> ($past(rsp_retry) && $past(second_try)));

  a_r5_error_completion: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ERROR) |=> (cpl_valid && cpl_err));

  a_r6_ok_completion: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT && rsp_done) |=> (cpl_valid && !cpl_err && !second_try));

  a_r7_zero_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT && rsp_retry && !rsp_done && retry_limit == '0) |=>
      (st == ST_YIELD || st == ST_ERROR));

  a_r8_grant_bus_free: assert property (@(posedge clk) disable iff (!rst_n)
    byp_grant |-> (st == ST_IDLE || st == ST_YIELD));

endmodule

bind bus_read_retry_ctrl bus_read_retry_ctrl_chk #(.LW(LW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .slot_full   (slot_full),
  .bus_issue   (bus_issue),
  .rsp_retry   (rsp_retry),
  .rsp_done    (rsp_done),
  .retry_limit (retry_limit),
  .byp_grant   (byp_grant),
  .cpl_valid   (cpl_valid),
  .cpl_err     (cpl_err),
  .st          (st),
  .second_try  (second_try),
  .retry_cnt   (retry_cnt)
);

// File: tb/tb_bus_read_retry_ctrl.sv
`timescale 1ns/1ps
module tb_bus_read_retry_ctrl;

  localparam int AW = 32;
  localparam int DW = 32;
  localparam int LW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic [AW-1:0] req_addr;
  logic          req_ready;
  logic          bus_issue;
  logic [AW-1:0] bus_addr;
  logic          rsp_retry;
  logic          rsp_done;
  logic [DW-1:0] rsp_data;
  logic [LW-1:0] retry_limit;
  logic          byp_pending;
  logic          byp_grant;
  logic          cpl_valid;
  logic          cpl_err;
  logic [AW-1:0] cpl_addr;
  logic [DW-1:0] cpl_data;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  bus_read_retry_ctrl #(.AW(AW), .DW(DW), .LW(LW)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
    .bus_issue(bus_issue), .bus_addr(bus_addr),
    .rsp_retry(rsp_retry), .rsp_done(rsp_done), .rsp_data(rsp_data),
    .retry_limit(retry_limit),
    .byp_pending(byp_pending), .byp_grant(byp_grant),
    .cpl_valid(cpl_valid), .cpl_err(cpl_err),
    .cpl_addr(cpl_addr), .cpl_data(cpl_data)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
    check(act === exp, tag, act, exp);
  endtask

  // Called at a falling edge with the controller idle and slot empty.
  task automatic push(input logic [AW-1:0] a);
    req_valid = 1'b1;
    req_addr  = a;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic answer_retry();
    rsp_retry = 1'b1;
    @(negedge clk);
    rsp_retry = 1'b0;
  endtask

  task automatic answer_done(input logic [DW-1:0] d);
    rsp_done = 1'b1;
    rsp_data = d;
    @(negedge clk);
    rsp_done = 1'b0;
  endtask

  // Pushes a read into an idle controller and checks the issue timing.
  task automatic start_read(input logic [AW-1:0] a, input string tag);
    push(a);
    eq({tag, " R2 no issue in accept cycle"}, bus_issue, 1'b0);
    @(negedge clk);
    eq({tag, " R2 issue one cycle after accept"}, bus_issue, 1'b1);
    eq({tag, " R2 issue address"}, bus_addr, a);
  endtask

  task automatic retries_within(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      eq({tag, " R2 pulse ends"}, bus_issue, 1'b0);
      answer_retry();
      eq({tag, " R3 reissue after retry within limit"}, bus_issue, 1'b1);
    end
  endtask

  task automatic t_reset();
    eq("R1 ready after reset", req_ready, 1'b1);
    eq("R2 no issue after reset", bus_issue, 1'b0);
    eq("R6 no completion after reset", cpl_valid, 1'b0);
    eq("R8 no grant without pending", byp_grant, 1'b0);
    byp_pending = 1'b1;
    #1;
    eq("R8 grant while idle", byp_grant, 1'b1);
    byp_pending = 1'b0;
    #1;
    eq("R8 grant follows pending when idle", byp_grant, 1'b0);
  endtask

  task automatic t_simple();
    retry_limit = 8'd3;
    start_read(32'h0000_1000, "simple");
    @(negedge clk);
    eq("R2 single pulse", bus_issue, 1'b0);
    eq("R6 not complete before answer", cpl_valid, 1'b0);
    answer_done(32'hCAFE_0001);
    eq("R6 completion valid", cpl_valid, 1'b1);
    eq("R6 completion ok", cpl_err, 1'b0);
    eq("R6 completion data", cpl_data, 32'hCAFE_0001);
    eq("R6 completion address", cpl_addr, 32'h0000_1000);
    @(negedge clk);
    eq("R6 completion single cycle", cpl_valid, 1'b0);
  endtask

  task automatic t_retries();
    retry_limit = 8'd3;
    start_read(32'h0000_2040, "retries");
    retries_within(3, "retries");
    eq("R3 reissue keeps address", bus_addr, 32'h0000_2040);
    @(negedge clk);
    answer_done(32'h1234_5678);
    eq("R3 ok after retries", cpl_valid && !cpl_err, 1'b1);
    eq("R6 data after retries", cpl_data, 32'h1234_5678);
  endtask

  task automatic t_yield();
    retry_limit = 8'd2;
    byp_pending = 1'b1;
    start_read(32'h0000_3000, "yield");
    eq("R8 no grant while issuing", byp_grant, 1'b0);
    retries_within(2, "yield");
    @(negedge clk);
    eq("R8 no grant while waiting", byp_grant, 1'b0);
    answer_retry();
    eq("R4 no issue after first overrun", bus_issue, 1'b0);
    eq("R4 grant while yielding", byp_grant, 1'b1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      eq("R4 held while traffic waits", bus_issue, 1'b0);
      eq("R4 grant held", byp_grant, 1'b1);
    end
    byp_pending = 1'b0;
    #1;
    eq("R4 grant drops with pending", byp_grant, 1'b0);
    @(negedge clk);
    eq("R4 reissue after traffic drains", bus_issue, 1'b1);
    eq("R4 reissue address", bus_addr, 32'h0000_3000);
    retries_within(2, "yield second");
    @(negedge clk);
    answer_done(32'hBEEF_0003);
    eq("R6 ok after yield", cpl_valid && !cpl_err, 1'b1);
    eq("R6 data after yield", cpl_data, 32'hBEEF_0003);
  endtask

  task automatic t_abandon();
    retry_limit = 8'd1;
    start_read(32'h0000_4080, "abandon");
    retries_within(1, "abandon");
    @(negedge clk);
    answer_retry();
    eq("R6 earlier ok read left no trace: yields", bus_issue, 1'b0);
    eq("R6 no completion on first overrun", cpl_valid, 1'b0);
    @(negedge clk);
    eq("R4 reissue with no waiting traffic", bus_issue, 1'b1);
    retries_within(1, "abandon second");
    @(negedge clk);
    answer_retry();
    eq("R5 no issue after second overrun", bus_issue, 1'b0);
    eq("R5 error not yet reported", cpl_valid, 1'b0);
    @(negedge clk);
    eq("R5 error completion valid", cpl_valid, 1'b1);
    eq("R5 error flag", cpl_err, 1'b1);
    eq("R5 error address", cpl_addr, 32'h0000_4080);
    @(negedge clk);
    eq("R9 idle after error", cpl_valid, 1'b0);
    eq("R9 no stray issue", bus_issue, 1'b0);
  endtask

  task automatic t_limit0();
    retry_limit = 8'd0;
    start_read(32'h0000_5000, "zero");
    @(negedge clk);
    answer_retry();
    eq("R7 first retry yields", bus_issue, 1'b0);
    @(negedge clk);
    eq("R7 reissue", bus_issue, 1'b1);
    @(negedge clk);
    answer_retry();
    eq("R7 second retry no issue", bus_issue, 1'b0);
    @(negedge clk);
    eq("R7 error after second retry", cpl_valid && cpl_err, 1'b1);
    @(negedge clk);
  endtask

  task automatic t_queue();
    retry_limit = 8'd4;
    start_read(32'h0000_6000, "queue A");
    @(negedge clk);
    eq("R1 slot free while A in flight", req_ready, 1'b1);
    push(32'h0000_6100);
    eq("R1 slot full after B", req_ready, 1'b0);
    push(32'h0000_6200);
    eq("R1 C refused", req_ready, 1'b0);
    eq("R2 B not issued while A in flight", bus_issue, 1'b0);
    answer_done(32'hAAAA_0000);
    eq("R9 A completes", cpl_addr, 32'h0000_6000);
    eq("R9 A ok", cpl_valid && !cpl_err, 1'b1);
    @(negedge clk);
    eq("R9 B issued next", bus_issue, 1'b1);
    eq("R1 B address held", bus_addr, 32'h0000_6100);
    eq("R1 slot free after B taken", req_ready, 1'b1);
    @(negedge clk);
    answer_done(32'hBBBB_0000);
    eq("R1 B completes", cpl_addr, 32'h0000_6100);
    eq("R1 B data", cpl_data, 32'hBBBB_0000);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      eq("R1 refused C never issued", bus_issue, 1'b0);
    end
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n       = 1'b0;
    req_valid   = 1'b0;
    req_addr    = '0;
    rsp_retry   = 1'b0;
    rsp_done    = 1'b0;
    rsp_data    = '0;
    retry_limit = 8'd3;
    byp_pending = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    @(negedge clk);
    t_simple();
    @(negedge clk);
    t_retries();
    @(negedge clk);
    t_yield();
    @(negedge clk);
    t_abandon();
    t_limit0();
    t_queue();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule